// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block watches the memory transactions that an arbiter forwards and flags the ones that touch a guarded region. It holds four independent watchpoints. Each one is programmed with an inclusive address window, a mask of operation codes it cares about and a mask of client IDs it cares about. A transaction hits a watchpoint when all three tests pass.

On the first hit, a watchpoint records the access: the address, the client ID, the operation code and the size. It keeps that record until software releases it with a per-watchpoint acknowledge. Each hit also sets a sticky status bit. Status is cleared by a separate interrupt-acknowledge write that carries one bit per watchpoint. A mask register selects which status bits drive the single interrupt line. A priority output names the lowest-numbered watchpoint that is pending.

All programming and read-back goes through a small word-addressed register port. Writes take effect on the next clock edge, and reads are combinational.

Top module: `acc_watch_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register that can be read returns zero, `irq` is low and `irq_src` is zero.
- R2: Watchpoint n hits when `txn_valid` is high and all of the following hold: its low bound ≤ `txn_addr` ≤ its high bound, bit `txn_client` of its client mask is set, and bit `txn_op` of its operation mask is set. Any other transaction has no effect on that watchpoint.
- R3: The register word at index 8n+k holds a field of watchpoint n: k=0 is the low bound, k=1 the high bound, k=2 the operation mask (bit i stands for op code i), and k=3 the client mask (bit i stands for client ID i). These words read back what was last written. Writes to indices 8n+4, 8n+5, 8n+6, 33 and 34 change nothing.
- R4: On a hit while the watchpoint is not holding a record, the watchpoint records the access. Index 8n+5 returns the address. Index 8n+6 returns the client ID in bits [7:0], the op code from bit 8 and the size from bit 16. Index 8n+4 returns a client mask containing only the hitting client's bit. Index 8n+7 reads 1 while a record is held.
- R5: While a record is held, later hits leave the address, client ID, op code and size unchanged. Each later hit ORs its client's bit into the word at index 8n+4.
- R6: Any write to index 8n+7 releases watchpoint n's record. The old values stay readable until the next hit. If a hit falls in the same cycle as the release, that hit becomes the new record.
- R7: A hit sets status bit n, which is read raw at index 33. The bit stays set until a write to index 35 with data bit n set. If a hit and that clearing write fall in the same cycle, the bit stays set.
- R8: Index 32 is the interrupt mask, bits [3:0]. Index 34 reads status AND mask. `irq` is high exactly when status AND mask is non-zero, starting in the cycle after the hit.
- R9: While `irq` is high, `irq_src` gives the lowest-numbered watchpoint whose status and mask bits are both set, so watchpoint 0 has the highest priority. While `irq` is low, `irq_src` is 0.
- R10: One transaction can hit several watchpoints at once. Each one records and sets status independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_addr | input | ADDR_W (32) | Transaction address |
| txn_client | input | CID_W (4) | Requesting client ID |
| txn_op | input | OP_W (2) | Operation code |
| txn_size | input | SIZE_W (3) | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | ADDR_W (32) | Register write data |
| reg_rdata | output | ADDR_W (32) | Register read data (combinational) |
| irq | output | 1 | Combined masked interrupt |
| irq_src | output | 2 | Highest-priority pending watchpoint |

## Verification
Two pairs of events can fall in the same cycle: a hit together with the release of that watchpoint's record, and a hit together with the interrupt-acknowledge write that clears its status bit. The bench lines up both pairs by driving `reg_we` to the release or clear address in the same cycle as a matching transaction. A behavioural model then decides the outcome. In the first case the new access must become the record. In the second case the status bit must stay set. The check reads the record words, the lock flag, the status word and `irq` right after that edge.

// File: rtl/acw_pkg.sv
// Package: shared constants for the access watchpoint unit.
// Assumes a word-indexed register space of 64 words, watchpoints packed
// on an 8-word stride, global words placed after the watchpoint block.
package acw_pkg;
    localparam int NUM_WP    = 4;
    localparam int WP_IW     = $clog2(NUM_WP);
    localparam int REG_AW    = 6;
    localparam int WP_STRIDE = 8;
    localparam int OFS_W     = $clog2(WP_STRIDE);

    typedef enum logic [OFS_W-1:0] {
        OFS_LO  = 3'd0,
        OFS_HI  = 3'd1,
        OFS_OPM = 3'd2,
        OFS_CLM = 3'd3,
        OFS_CCL = 3'd4,
        OFS_CAD = 3'd5,
        OFS_CDT = 3'd6,
        OFS_ACK = 3'd7
    } wp_ofs_e;

    localparam logic [REG_AW-1:0] GADR_MASK = REG_AW'(NUM_WP * WP_STRIDE);
    localparam logic [REG_AW-1:0] GADR_RAW  = REG_AW'(NUM_WP * WP_STRIDE + 1);
    localparam logic [REG_AW-1:0] GADR_MSK  = REG_AW'(NUM_WP * WP_STRIDE + 2);
    localparam logic [REG_AW-1:0] GADR_IACK = REG_AW'(NUM_WP * WP_STRIDE + 3);

    localparam int DET_OP_LSB = 8;
    localparam int DET_SZ_LSB = 16;
endpackage

// File: rtl/acw_wp.sv
// Module: one watchpoint. Holds its window and masks, matches the
// presented transaction combinationally and keeps a first-hit record
// that later hits cannot overwrite until released.
// Assumes CID_W = clog2(NUM_CLIENTS) and OP_N = 2**OP_W from the parent.
module acw_wp #(
    parameter int ADDR_W      = 32,
    parameter int NUM_CLIENTS = 16,
    parameter int CID_W       = 4,
    parameter int OP_W        = 2,
    parameter int OP_N        = 4,
    parameter int SIZE_W      = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             cfg_we,
    input  logic [ADDR_W-1:0]      wdata,
    input  logic                   ack_i,
    input  logic                   txn_valid,
    input  logic [ADDR_W-1:0]      txn_addr,
    input  logic [CID_W-1:0]       txn_client,
    input  logic [OP_W-1:0]        txn_op,
    input  logic [SIZE_W-1:0]      txn_size,
    output logic [ADDR_W-1:0]      lo_o,
    output logic [ADDR_W-1:0]      hi_o,
    output logic [OP_N-1:0]        opm_o,
    output logic [NUM_CLIENTS-1:0] clm_o,
    output logic                   hit_o,
    output logic                   lock_o,
    output logic [NUM_CLIENTS-1:0] cap_cl_o,
    output logic [ADDR_W-1:0]      cap_addr_o,
    output logic [CID_W-1:0]       cap_cid_o,
    output logic [OP_W-1:0]        cap_op_o,
    output logic [SIZE_W-1:0]      cap_size_o
);
    logic [NUM_CLIENTS-1:0] cl_bit;
    logic                   take;

    // Purpose: decode the client bit and decide whether this hit opens a record.
    assign cl_bit = NUM_CLIENTS'(1) << txn_client;
    assign hit_o  = txn_valid && (txn_addr >= lo_o) && (txn_addr <= hi_o)
                    && clm_o[txn_client] && opm_o[txn_op];
    assign take   = hit_o && (!lock_o || ack_i);

    // Purpose: hold the programmed window and masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o  <= '0;
            hi_o  <= '0;
            opm_o <= '0;
            clm_o <= '0;
        end else begin
            if (cfg_we[0]) lo_o  <= wdata;
            if (cfg_we[1]) hi_o  <= wdata;
            if (cfg_we[2]) opm_o <= wdata[OP_N-1:0];
            if (cfg_we[3]) clm_o <= wdata[NUM_CLIENTS-1:0];
        end
    end

    // Purpose: keep the first-hit record and accumulate later clients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o     <= 1'b0;
            cap_cl_o   <= '0;
            cap_addr_o <= '0;
            cap_cid_o  <= '0;
            cap_op_o   <= '0;
            cap_size_o <= '0;
        end else begin
            lock_o <= (lock_o && !ack_i) || hit_o;
            if (take) begin
                cap_cl_o   <= cl_bit;
                cap_addr_o <= txn_addr;
                cap_cid_o  <= txn_client;
                cap_op_o   <= txn_op;
                cap_size_o <= txn_size;
            end else if (hit_o) begin
                cap_cl_o <= cap_cl_o | cl_bit;
            end
        end
    end

    AST_HIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> lock_o); // R4
    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !ack_i) |=> ($stable(cap_addr_o) && $stable(cap_cid_o)
                                && $stable(cap_op_o) && $stable(cap_size_o))); // R5
    AST_CLIENTS_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !ack_i) |=> ((cap_cl_o & $past(cap_cl_o)) == $past(cap_cl_o))); // R5
endmodule

// File: rtl/acw_irq.sv
// Module: sticky hit status, interrupt mask, combined interrupt and
// fixed-priority source index (lowest watchpoint number wins).
// Assumes hit_i is a per-watchpoint pulse valid in the cycle it is set.
module acw_irq #(
    parameter int NUM_WP = 4,
    parameter int WP_IW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] hit_i,
    input  logic              mask_we,
    input  logic              iack_we,
    input  logic [NUM_WP-1:0] wdata,
    output logic [NUM_WP-1:0] status_o,
    output logic [NUM_WP-1:0] mask_o,
    output logic              irq_o,
    output logic [WP_IW-1:0]  src_o
);
    logic [NUM_WP-1:0] pend;

    // Purpose: set status on hits, clear on acknowledge; a new hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            mask_o   <= '0;
        end else begin
            status_o <= (status_o & ~(iack_we ? wdata : '0)) | hit_i;
            if (mask_we) mask_o <= wdata;
        end
    end

    // Purpose: form the masked pending set and pick the lowest index.
    always_comb begin
        pend  = status_o & mask_o;
        irq_o = |pend;
        src_o = '0;
        for (int i = NUM_WP - 1; i >= 0; i--) begin
            if (pend[i]) src_o = WP_IW'(i);
        end
    end

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((status_o & $past(hit_i)) == $past(hit_i))); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        iack_we |=> ((status_o & $past(wdata & ~hit_i)) == '0)); // R7
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o); // R8
    AST_SRC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[src_o] && mask_o[src_o])); // R9
    AST_SRC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_o & mask_o & NUM_WP'((1 << src_o) - 1)) == '0)); // R9
endmodule

// File: rtl/acc_watch_unit.sv
// Module: top of the access watchpoint unit. Decodes the register port,
// instantiates one acw_wp per watchpoint and the shared acw_irq, and
// multiplexes read data. Reads are combinational and side-effect free.
// Assumes ADDR_W >= NUM_CLIENTS and ADDR_W > DET_SZ_LSB + SIZE_W.
module acc_watch_unit
    import acw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_CLIENTS = 16,
    parameter int OP_W        = 2,
    parameter int SIZE_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           txn_valid,
    input  logic [ADDR_W-1:0]              txn_addr,
    input  logic [$clog2(NUM_CLIENTS)-1:0] txn_client,
    input  logic [OP_W-1:0]                txn_op,
    input  logic [SIZE_W-1:0]              txn_size,
    input  logic                           reg_we,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [ADDR_W-1:0]              reg_wdata,
    output logic [ADDR_W-1:0]              reg_rdata,
    output logic                           irq,
    output logic [WP_IW-1:0]               irq_src
);
    localparam int CID_W  = $clog2(NUM_CLIENTS);
    localparam int OP_N   = 1 << OP_W;
    localparam int DATA_W = ADDR_W;

    logic [ADDR_W-1:0]      lo_a     [NUM_WP];
    logic [ADDR_W-1:0]      hi_a     [NUM_WP];
    logic [OP_N-1:0]        opm_a    [NUM_WP];
    logic [NUM_CLIENTS-1:0] clm_a    [NUM_WP];
    logic [NUM_CLIENTS-1:0] ccl_a    [NUM_WP];
    logic [ADDR_W-1:0]      cad_a    [NUM_WP];
    logic [CID_W-1:0]       cid_a    [NUM_WP];
    logic [OP_W-1:0]        cop_a    [NUM_WP];
    logic [SIZE_W-1:0]      csz_a    [NUM_WP];
    logic [NUM_WP-1:0]      hit_v;
    logic [NUM_WP-1:0]      lock_v;
    logic [NUM_WP-1:0]      status_v;
    logic [NUM_WP-1:0]      mask_v;

    logic                   is_wp;
    logic [WP_IW-1:0]       wp_idx;
    wp_ofs_e                ofs;

    // Purpose: split the register index into watchpoint number and word offset.
    assign is_wp  = reg_addr < REG_AW'(NUM_WP * WP_STRIDE);
    assign wp_idx = reg_addr[OFS_W +: WP_IW];
    assign ofs    = wp_ofs_e'(reg_addr[OFS_W-1:0]);

    for (genvar n = 0; n < NUM_WP; n++) begin : g_wp
        logic       sel;
        logic [3:0] cfg_we;
        assign sel    = reg_we && is_wp && (wp_idx == WP_IW'(n));
        assign cfg_we = {sel && (ofs == OFS_CLM), sel && (ofs == OFS_OPM),
                         sel && (ofs == OFS_HI),  sel && (ofs == OFS_LO)};

        acw_wp #(
            .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W),
            .OP_W(OP_W), .OP_N(OP_N), .SIZE_W(SIZE_W)
        ) u_wp (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we),
            .wdata      (reg_wdata),
            .ack_i      (sel && (ofs == OFS_ACK)),
            .txn_valid  (txn_valid),
            .txn_addr   (txn_addr),
            .txn_client (txn_client),
            .txn_op     (txn_op),
            .txn_size   (txn_size),
            .lo_o       (lo_a[n]),
            .hi_o       (hi_a[n]),
            .opm_o      (opm_a[n]),
            .clm_o      (clm_a[n]),
            .hit_o      (hit_v[n]),
            .lock_o     (lock_v[n]),
            .cap_cl_o   (ccl_a[n]),
            .cap_addr_o (cad_a[n]),
            .cap_cid_o  (cid_a[n]),
            .cap_op_o   (cop_a[n]),
            .cap_size_o (csz_a[n])
        );
    end

    acw_irq #(.NUM_WP(NUM_WP), .WP_IW(WP_IW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_v),
        .mask_we  (reg_we && (reg_addr == GADR_MASK)),
        .iack_we  (reg_we && (reg_addr == GADR_IACK)),
        .wdata    (reg_wdata[NUM_WP-1:0]),
        .status_o (status_v),
        .mask_o   (mask_v),
        .irq_o    (irq),
        .src_o    (irq_src)
    );

    // Purpose: select the read word for the presented register index.
    always_comb begin
        reg_rdata = '0;
        if (is_wp) begin
            case (ofs)
                OFS_LO:  reg_rdata = lo_a[wp_idx];
                OFS_HI:  reg_rdata = hi_a[wp_idx];
                OFS_OPM: reg_rdata = DATA_W'(opm_a[wp_idx]);
                OFS_CLM: reg_rdata = DATA_W'(clm_a[wp_idx]);
                OFS_CCL: reg_rdata = DATA_W'(ccl_a[wp_idx]);
                OFS_CAD: reg_rdata = cad_a[wp_idx];
                OFS_CDT: begin
                    reg_rdata[CID_W-1:0]             = cid_a[wp_idx];
                    reg_rdata[DET_OP_LSB +: OP_W]    = cop_a[wp_idx];
                    reg_rdata[DET_SZ_LSB +: SIZE_W]  = csz_a[wp_idx];
                end
                default: reg_rdata = DATA_W'(lock_v[wp_idx]);
            endcase
        end else if (reg_addr == GADR_MASK) begin
            reg_rdata = DATA_W'(mask_v);
        end else if (reg_addr == GADR_RAW) begin
            reg_rdata = DATA_W'(status_v);
        end else if (reg_addr == GADR_MSK) begin
            reg_rdata = DATA_W'(status_v & mask_v);
        end
    end
endmodule

// File: tb/acc_watch_unit_bench.sv
// Bench: behavioural reference model of the watchpoint unit, advanced on
// every clock and compared with the design's interrupt outputs each cycle
// and with every register word at chosen points.
module acc_watch_unit_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_valid = 1'b0;
    logic [AW-1:0] txn_addr = '0;
    logic [3:0]    txn_client = '0;
    logic [1:0]    txn_op = '0;
    logic [2:0]    txn_size = '0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq;
    logic [1:0]    irq_src;

    int vectors = 0;
    int miscompares = 0;

    // model state
    logic [31:0] m_lo [4], m_hi [4], m_opm [4], m_clm [4];
    logic [31:0] m_ccl [4], m_cad [4], m_cdt [4];
    logic [3:0]  m_lock, m_stat, m_mask;

    acc_watch_unit u_acc_watch_unit (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_client(txn_client), .txn_op(txn_op), .txn_size(txn_size),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_src(irq_src)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mdl_read(input int a);
        if (a < 32) begin
            case (a % 8)
                0: return m_lo[a/8];
                1: return m_hi[a/8];
                2: return m_opm[a/8];
                3: return m_clm[a/8];
                4: return m_ccl[a/8];
                5: return m_cad[a/8];
                6: return m_cdt[a/8];
                default: return {31'b0, m_lock[a/8]};
            endcase
        end
        if (a == 32) return {28'b0, m_mask};
        if (a == 33) return {28'b0, m_stat};
        if (a == 34) return {28'b0, m_stat & m_mask};
        return 32'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int n = 0; n < 4; n++) begin
            m_lo[n] = 0; m_hi[n] = 0; m_opm[n] = 0; m_clm[n] = 0;
            m_ccl[n] = 0; m_cad[n] = 0; m_cdt[n] = 0;
        end
        m_lock = 0; m_stat = 0; m_mask = 0;
    endtask

    // compare the interrupt outputs against the model
    task automatic check_irq(input string tag);
        logic [3:0] p;
        int s;
        p = m_stat & m_mask;
        s = 0;
        for (int n = 3; n >= 0; n--) if (p[n]) s = n;
        check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, |p});
        check({tag, " R9 irq_src"}, {30'b0, irq_src}, s);
    endtask

    task automatic read_chk(input string tag, input int a);
        reg_addr = 6'(a);
        #1;
        check($sformatf("%s reg[%0d]", tag, a), reg_rdata, mdl_read(a));
    endtask

    task automatic chk_all(input string tag);
        for (int a = 0; a < 36; a++) read_chk(tag, a);
    endtask

    // one clock: drive inputs, advance the model, compare outputs after the edge
    task automatic tick(input logic v, input logic [31:0] ad, input int cl, input int op,
                        input int sz, input logic we, input int ra, input logic [31:0] wd);
        logic [3:0] hit;
        txn_valid = v; txn_addr = ad; txn_client = 4'(cl); txn_op = 2'(op);
        txn_size = 3'(sz); reg_we = we; reg_addr = 6'(ra); reg_wdata = wd;
        for (int n = 0; n < 4; n++)
            hit[n] = v && ad >= m_lo[n] && ad <= m_hi[n] && m_clm[n][cl] && m_opm[n][op];
        @(posedge clk);
        for (int n = 0; n < 4; n++) begin
            logic ack;
            ack = we && (ra == n * 8 + 7);
            if (hit[n] && (!m_lock[n] || ack)) begin
                m_ccl[n] = 32'(1) << cl;
                m_cad[n] = ad;
                m_cdt[n] = (32'(sz) << 16) | (32'(op) << 8) | 32'(cl);
            end else if (hit[n]) begin
                m_ccl[n] = m_ccl[n] | (32'(1) << cl);
            end
            m_lock[n] = (m_lock[n] && !ack) || hit[n];
            if (we && ra == n * 8 + 0) m_lo[n] = wd;
            if (we && ra == n * 8 + 1) m_hi[n] = wd;
            if (we && ra == n * 8 + 2) m_opm[n] = wd & 32'hF;
            if (we && ra == n * 8 + 3) m_clm[n] = wd & 32'hFFFF;
        end
        m_stat = (m_stat & ~((we && ra == 35) ? wd[3:0] : 4'b0)) | hit;
        if (we && ra == 32) m_mask = wd[3:0];
        @(negedge clk);
        txn_valid = 1'b0; reg_we = 1'b0;
        check_irq("cycle");
    endtask

    task automatic wr(input int ra, input logic [31:0] wd);
        tick(1'b0, 0, 0, 0, 0, 1'b1, ra, wd);
    endtask

    task automatic txn(input logic [31:0] ad, input int cl, input int op, input int sz);
        tick(1'b1, ad, cl, op, sz, 1'b0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_irq("R1 reset");
        chk_all("R1 reset");

        // R3: program watchpoint 0, poke read-only words, enable all interrupts
        wr(0, 32'h0000_1000); wr(1, 32'h0000_10FF); wr(2, 32'h2); wr(3, 32'h28);
        wr(4, 32'hFFFF_FFFF); wr(5, 32'h1234); wr(6, 32'h77); wr(33, 32'hF); wr(34, 32'hF);
        wr(32, 32'hF);
        chk_all("R3 config");

        // R2 misses: above window, wrong client, wrong op
        txn(32'h0000_1100, 3, 1, 1);
        txn(32'h0000_0FFF, 3, 1, 1);
        txn(32'h0000_1010, 4, 1, 1);
        txn(32'h0000_1010, 3, 0, 1);
        chk_all("R2 miss");

        // R4: hit on the low bound
        txn(32'h0000_1000, 3, 1, 2);
        chk_all("R4 first hit");

        // R5: later hit on the high bound from client 5
        txn(32'h0000_10FF, 5, 1, 6);
        chk_all("R5 held record");

        // R7: clear status only; record remains
        wr(35, 32'h1);
        chk_all("R7 clear");
        txn(32'h0000_1080, 3, 1, 4);
        chk_all("R7 reraise");

        // R6: release alone, then release together with a hit
        wr(7, 0);
        chk_all("R6 release");
        tick(1'b1, 32'h0000_1040, 5, 1, 7, 1'b1, 7, 0);
        chk_all("R6 release with hit");

        // R7: clear together with a hit keeps the status bit
        tick(1'b1, 32'h0000_1041, 3, 1, 1, 1'b1, 35, 32'h1);
        chk_all("R7 clear with hit");
        wr(35, 32'hF);

        // R10 / R9: overlapping windows on watchpoints 1..3
        for (int n = 1; n < 4; n++) begin
            wr(n * 8 + 0, 32'h2000); wr(n * 8 + 1, 32'h2FFF);
            wr(n * 8 + 2, 32'hF); wr(n * 8 + 3, 32'hFFFF);
        end
        wr(32, 32'hC);
        txn(32'h0000_2800, 9, 2, 3);
        chk_all("R10 multi hit");
        wr(32, 32'hE);
        chk_all("R9 priority");
        wr(35, 32'h2);
        chk_all("R8 masked status");
        wr(32, 32'h0);
        chk_all("R8 all masked");
        wr(32, 32'hF);

        // mixed traffic with random releases and clears
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6)
                txn(32'h0000_0F80 + 32'($urandom_range(0, 32'h1100)),
                    $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 7));
            else if (r < 8)
                wr($urandom_range(0, 3) * 8 + 7, 0);
            else
                tick(1'b1, 32'h0000_2000 + 32'($urandom_range(0, 4095)), $urandom_range(0, 15),
                     $urandom_range(0, 3), $urandom_range(0, 7), 1'b1, 35, 32'($urandom_range(0, 15)));
            if (i % 25 == 0) chk_all("R2 R4 R5 R6 R7 R10 mixed");
        end
        chk_all("R5 final");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule